// File: doc/BRIEF.md
# Feed-Sequence Watchdog Timer

The block is a down-counting watchdog that software controls through a small register file. Software first loads a reload constant and picks the counting source. It then sets the enable and reset-arm bits in the mode register. Finally it services the timer with an ordered two-write unlock pattern on the feed register. The counter is advanced by a fixed divide-by-4 prescaler. If software stops servicing, the count runs out and the block raises a one-cycle system reset request.

A sticky timeout flag records that the watchdog caused the restart. The system reset (`sys_rst_i`) returns every other part of the block to its reset state, but it leaves this flag alone. Software can therefore read the flag after the restart. Only the power-on reset (`rst_ni`) or a software write of 0 clears it.

Registers, by word address, with all fields at bit 0 upward:
- 0: mode. Bit 0 is enable, bit 1 is reset arm, bit 2 is the timeout flag, bit 3 is active (read-only).
- 1: reload constant.
- 2: feed (write-only, reads 0).
- 3: clock select, bit 0.
- 4: current count (read-only).

Top module: `fwdt_top`

## Requirements
- R1: After power-on reset, mode reads 0, the reload constant and the count both read TC_RST (0xFF), clock select reads 0 and `rst_req_o` is low.
- R2: A feed-register write of 0xAA followed by a feed-register write of 0x55 is a valid feed. It loads the count from the reload constant and restarts the prescaler phase. Writes to other registers between the two bytes do not break the pair.
- R3: A lone 0x55 has no effect. After 0xAA, any other feed write aborts the sequence, including a second 0xAA, so a following 0x55 does not reload.
- R4: Mode bits 0 and 1 can only be set by writing 1; writing 0 does not clear them. Counting starts only at the first valid feed made while enable is set, and active (bit 3) reads 1 from then on.
- R5: While active, the count decrements once every 4 source ticks. Clock select bit 0 = 1 makes every clock a source tick; 0 uses `osc_tick_i`.
- R6: On a prescaled tick with the count at 0, the count reloads and the timeout flag (bit 2) sets. If reset arm is set, `rst_req_o` is high for exactly one cycle. The request follows the feed by 4*(constant+1) source ticks.
- R7: The timeout flag survives `sys_rst_i`. It is cleared by a mode write with bit 2 = 0 or by `rst_ni`. Writing 1 to bit 2 never sets it.
- R8: `sys_rst_i` (synchronous) returns enable, arm, active, reload constant, clock select, count, prescaler and feed sequence to their reset values.
- R9: A valid feed that lands in the same cycle as an expiring tick wins: no request is raised and the count reloads.
- R10: Expiry with reset arm clear sets the timeout flag but raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_i | input | 1 | System reset, synchronous; keeps the timeout flag |
| osc_tick_i | input | 1 | Alternate source tick enable |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for addr_i (combinational) |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The critical collision is a valid feed completing on the very edge where a prescaled tick finds the count at zero. With a reload constant of 0 and every clock a source tick, the bench places the closing 0x55 exactly four cycles after the previous feed, and repeats this several times. The bench then judges that no reset request appeared and that the count reloaded. It also checks that the request does arrive four cycles after the servicing stops. A behavioural reference model compares the read data and the request on every clock throughout.

// File: rtl/fwdt_pkg.sv
package fwdt_pkg;
  typedef enum logic [2:0] {
    A_MODE = 3'd0,
    A_TC   = 3'd1,
    A_FEED = 3'd2,
    A_CSEL = 3'd3,
    A_CNT  = 3'd4
  } fwdt_addr_t;

  typedef enum logic {FS_IDLE, FS_ARMED} feed_st_t;

  localparam logic [7:0] FEED_KEY1 = 8'hAA;
  localparam logic [7:0] FEED_KEY2 = 8'h55;

  localparam int MB_EN     = 0;
  localparam int MB_RST_EN = 1;
  localparam int MB_TOF    = 2;
endpackage

// File: rtl/fwdt_feed_seq.sv
module fwdt_feed_seq
  import fwdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sys_rst_i,
  input  logic       wr_i,
  input  logic [7:0] data_i,
  output logic       ok_o
);
  feed_st_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        st_q <= FS_IDLE;
    else if (sys_rst_i) st_q <= FS_IDLE;
    else if (wr_i)      st_q <= (st_q == FS_IDLE && data_i == FEED_KEY1) ? FS_ARMED : FS_IDLE;
  end

  assign ok_o = wr_i && !sys_rst_i && (st_q == FS_ARMED) && (data_i == FEED_KEY2);
endmodule

// File: rtl/fwdt_prescale.sv
module fwdt_prescale #(
  parameter int PRE_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_i,
  input  logic run_i,
  input  logic src_tick_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] PMAX = PW'(PRE_DIV - 1);

  generate
    if (PRE_DIV > 1) begin : g_div
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 pre_q <= '0;
        else if (sys_rst_i || clr_i) pre_q <= '0;
        else if (run_i && src_tick_i) pre_q <= (pre_q == PMAX) ? '0 : pre_q + 1'b1;
      end
      assign tick_o = run_i && src_tick_i && !clr_i && (pre_q == PMAX);
    end else begin : g_thru
      logic unused_w;
      assign unused_w = clk_i ^ rst_ni ^ sys_rst_i ^ PMAX[0];
      assign tick_o = run_i && src_tick_i && !clr_i;
    end
  endgenerate
endmodule

// File: rtl/fwdt_counter.sv
module fwdt_counter #(
  parameter int              CNT_W  = 24,
  parameter logic [CNT_W-1:0] TC_RST = CNT_W'(8'hFF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sys_rst_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && tick_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= TC_RST;
    else if (sys_rst_i)          cnt_q <= TC_RST;
    else if (load_i || expire_o) cnt_q <= load_val_i;
    else if (run_i && tick_i)    cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fwdt_top.sv
module fwdt_top
  import fwdt_pkg::*;
#(
  parameter int              CNT_W   = 24,
  parameter logic [CNT_W-1:0] TC_RST  = CNT_W'(8'hFF),
  parameter int              PRE_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sys_rst_i,
  input  logic             osc_tick_i,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             rst_req_o
);
  fwdt_addr_t       addr_e;
  logic             wr_mode, wr_tc, wr_feed, wr_csel;
  logic             en_q, rst_en_q, tof_q, active_q, sel_q, rst_req_q;
  logic [CNT_W-1:0] tc_q, cnt_q;
  logic             feed_ok, src_tick, pre_tick, expire;

  assign addr_e  = fwdt_addr_t'(addr_i);
  assign wr_mode = we_i && (addr_e == A_MODE);
  assign wr_tc   = we_i && (addr_e == A_TC);
  assign wr_feed = we_i && (addr_e == A_FEED);
  assign wr_csel = we_i && (addr_e == A_CSEL);

  fwdt_feed_seq u_feed (
    .clk_i, .rst_ni, .sys_rst_i,
    .wr_i   (wr_feed),
    .data_i (wdata_i[7:0]),
    .ok_o   (feed_ok)
  );

  assign src_tick = sel_q ? 1'b1 : osc_tick_i;

  fwdt_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk_i, .rst_ni, .sys_rst_i,
    .run_i      (active_q),
    .src_tick_i (src_tick),
    .clr_i      (feed_ok),
    .tick_o     (pre_tick)
  );

  fwdt_counter #(.CNT_W(CNT_W), .TC_RST(TC_RST)) u_cnt (
    .clk_i, .rst_ni, .sys_rst_i,
    .load_i     (feed_ok),
    .load_val_i (tc_q),
    .run_i      (active_q),
    .tick_i     (pre_tick),
    .cnt_o      (cnt_q),
    .expire_o   (expire)
  );

  // control registers; enable and arm are set-only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      rst_en_q  <= 1'b0;
      active_q  <= 1'b0;
      sel_q     <= 1'b0;
      tc_q      <= TC_RST;
      rst_req_q <= 1'b0;
    end else if (sys_rst_i) begin
      en_q      <= 1'b0;
      rst_en_q  <= 1'b0;
      active_q  <= 1'b0;
      sel_q     <= 1'b0;
      tc_q      <= TC_RST;
      rst_req_q <= 1'b0;
    end else begin
      if (wr_mode && wdata_i[MB_EN])     en_q     <= 1'b1;
      if (wr_mode && wdata_i[MB_RST_EN]) rst_en_q <= 1'b1;
      if (en_q && feed_ok)               active_q <= 1'b1;
      if (wr_csel)                       sel_q    <= wdata_i[0];
      if (wr_tc)                         tc_q     <= wdata_i;
      rst_req_q <= expire && rst_en_q;
    end
  end

  // timeout flag: only power-on reset or software clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          tof_q <= 1'b0;
    else if (sys_rst_i)                   tof_q <= tof_q;
    else if (expire)                      tof_q <= 1'b1;
    else if (wr_mode && !wdata_i[MB_TOF]) tof_q <= 1'b0;
  end

  always_comb begin
    unique case (addr_e)
      A_MODE:  rdata_o = CNT_W'({active_q, tof_q, rst_en_q, en_q});
      A_TC:    rdata_o = tc_q;
      A_CSEL:  rdata_o = CNT_W'(sel_q);
      A_CNT:   rdata_o = cnt_q;
      default: rdata_o = '0;
    endcase
  end

  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/fwdt_chk.sv
module fwdt_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sys_rst_i,
  input logic             rst_req_o,
  input logic             en_q,
  input logic             active_q,
  input logic             tof_q,
  input logic             feed_ok,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] tc_q
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R6
  AST_REQ_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> tof_q); // R6
  AST_FEED_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (feed_ok && !sys_rst_i) |=> (cnt_q == $past(tc_q))); // R2
  AST_FEED_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed_ok |=> !rst_req_o); // R9
  AST_ENABLE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !sys_rst_i) |=> en_q); // R4
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |=> !rst_req_o); // R4
  AST_FLAG_KEEP_SYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tof_q && sys_rst_i) |=> tof_q); // R7
endmodule

bind fwdt_top fwdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sys_rst_i (sys_rst_i),
  .rst_req_o (rst_req_o),
  .en_q      (en_q),
  .active_q  (active_q),
  .tof_q     (tof_q),
  .feed_ok   (feed_ok),
  .cnt_q     (cnt_q),
  .tc_q      (tc_q)
);

// File: tb/fwdt_top_tb_top.sv
`timescale 1ns/1ps
module fwdt_top_tb_top;
  localparam int W = 24;
  localparam logic [2:0] AM = 3'd0, AT = 3'd1, AF = 3'd2, AS = 3'd3, AC = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0, sys_rst = 1'b0, osc = 1'b0, we = 1'b0;
  logic [2:0] addr = AC;
  logic [W-1:0] wdata = '0, rdata;
  logic req;
  int n_chk = 0, n_bad = 0, req_cnt = 0;
  bit chk_on = 0, done = 0;

  always #5 clk = ~clk;

  fwdt_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sys_rst_i(sys_rst), .osc_tick_i(osc),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(req)
  );

  // behavioural reference state
  int m_en, m_arm, m_tof, m_act, m_sel, m_tc, m_cnt, m_pre, m_key, m_req;

  task automatic m_reset(bit keep_flag);
    m_en = 0; m_arm = 0; m_act = 0; m_sel = 0; m_tc = 255; m_cnt = 255;
    m_pre = 0; m_key = 0; m_req = 0;
    if (!keep_flag) m_tof = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset(0);
    else if (sys_rst) m_reset(1);
    else begin
      bit fok, src, tk, ex;
      int d;
      d   = int'(wdata);
      fok = we && addr == AF && m_key == 1 && (d % 256) == 'h55;
      if (we && addr == AF) m_key = (m_key == 0 && (d % 256) == 'hAA) ? 1 : 0;
      src = m_sel ? 1 : osc;
      tk  = m_act && src && m_pre == 3 && !fok;
      ex  = tk && m_cnt == 0;
      m_req = ex && m_arm;
      if (ex) m_tof = 1;
      else if (we && addr == AM && !wdata[2]) m_tof = 0;
      if (fok && m_en) m_act = 1;
      if (fok) m_pre = 0;
      else if (m_act && src) m_pre = (m_pre + 1) % 4;
      if (fok || ex) m_cnt = m_tc;
      else if (tk) m_cnt = m_cnt - 1;
      if (we && addr == AM && wdata[0]) m_en = 1;
      if (we && addr == AM && wdata[1]) m_arm = 1;
      if (we && addr == AT) m_tc = d;
      if (we && addr == AS) m_sel = wdata[0];
    end
  end

  function automatic int m_read(logic [2:0] a);
    case (a)
      AM: return m_en + 2*m_arm + 4*m_tof + 8*m_act;
      AT: return m_tc;
      AS: return m_sel;
      AC: return m_cnt;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (req) req_cnt++;
    if (chk_on) begin
      chk("model R6 rst_req", int'(req), m_req);
      chk("model R2 rdata", int'(rdata), m_read(addr));
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic wr(logic [2:0] a, int d);
    addr = a; wdata = W'(d); we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0; addr = AC;
  endtask
  task automatic rd(logic [2:0] a, output int d);
    addr = a; #1; d = int'(rdata); addr = AC;
  endtask
  task automatic feed();
    wr(AF, 'hAA); wr(AF, 'h55);
  endtask
  task automatic pulse_sys();
    sys_rst = 1'b1; @(posedge clk); #1; sys_rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      repeat (2) @(posedge clk);
      #1 osc = 1'b1;
      @(posedge clk);
      #1 osc = 1'b0;
    end
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int v, n, r0, prev;
    idle(3);
    @(posedge clk); #1 rst_n = 1'b1;
    chk_on = 1;
    // R1 reset state
    rd(AM, v); chk("R1 mode", v, 0);
    rd(AT, v); chk("R1 tc", v, 255);
    rd(AC, v); chk("R1 cnt", v, 255);
    rd(AS, v); chk("R1 csel", v, 0);
    chk("R1 req", int'(req), 0);

    // R4 enable without feed does not count
    wr(AT, 5); wr(AS, 1); wr(AM, 3);
    idle(10);
    rd(AM, v); chk("R4 not active before feed", v, 3);
    rd(AC, v); chk("R4 no counting", v, 255);

    // R3 broken sequences
    wr(AF, 'h55); idle(1);
    rd(AC, v); chk("R3 lone 0x55", v, 255);
    wr(AF, 'hAA); wr(AF, 'hAA); wr(AF, 'h55);
    rd(AC, v); chk("R3 double 0xAA aborts", v, 255);
    wr(AF, 'hAA); wr(AF, 'h12); wr(AF, 'h55);
    rd(AC, v); chk("R3 other byte aborts", v, 255);

    // R2 valid feed with an unrelated write in between
    wr(AF, 'hAA); wr(AT, 5); wr(AF, 'h55);
    rd(AC, v); chk("R2 reload", v, 5);
    rd(AM, v); chk("R4 active after feed", v, 11);

    // R5/R6 expiry timing: 4*(5+1) edges
    n = 0; r0 = req_cnt;
    while (n < 200) begin
      @(posedge clk); n++; #1;
      if (req) break;
    end
    chk("R6 cycles to request", n, 24);
    rd(AM, v); chk("R6 flag set", (v >> 2) & 1, 1);
    rd(AC, v); chk("R6 reload on expiry", v, 5);
    idle(1);
    chk("R6 one cycle", int'(req), 0);

    // R4 enable not clearable; R7 flag write semantics
    wr(AM, 'h4); rd(AM, v); chk("R7 write 1 keeps flag", (v >> 2) & 1, 1);
    wr(AM, 'h0); rd(AM, v); chk("R4 enable sticky", v & 3, 3);
    chk("R7 write 0 clears flag", (v >> 2) & 1, 0);
    feed(); idle(30);
    rd(AM, v); chk("R6 flag set again", (v >> 2) & 1, 1);

    // R7/R8 system reset keeps only the flag
    pulse_sys();
    rd(AM, v); chk("R7 flag survives sys reset", v, 4);
    rd(AT, v); chk("R8 tc reset", v, 255);
    rd(AC, v); chk("R8 cnt reset", v, 255);
    rd(AS, v); chk("R8 csel reset", v, 0);

    // R9 feed coinciding with expiring tick
    wr(AM, 0); wr(AT, 0); wr(AS, 1); wr(AM, 3); feed();
    r0 = req_cnt;
    for (int i = 0; i < 5; i++) begin
      idle(2); wr(AF, 'hAA); wr(AF, 'h55);
    end
    chk("R9 no request on collision", req_cnt - r0, 0);
    rd(AC, v); chk("R9 count reloaded", v, 0);
    idle(6);
    chk("R9 request after stop", req_cnt - r0, 1);

    // R10 expiry without reset arm
    pulse_sys();
    wr(AM, 0); wr(AT, 2); wr(AS, 1); wr(AM, 1); feed();
    r0 = req_cnt;
    idle(15);
    rd(AM, v); chk("R10 flag set", (v >> 2) & 1, 1);
    chk("R10 no request", req_cnt - r0, 0);

    // R5 alternate source: 4 osc ticks per decrement
    pulse_sys();
    wr(AT, 3); wr(AM, 3); feed();
    rd(AC, prev); n = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk);
      if (osc) n++;
      #1; rd(AC, v);
      if (v != prev) break;
    end
    chk("R5 osc ticks per step", n, 4);
    chk("R5 decrement by one", v, 2);

    // R7 power-on reset clears flag
    idle(60);
    rd(AM, v); chk("R7 flag before por", (v >> 2) & 1, 1);
    chk_on = 0; rst_n = 1'b0; idle(2); rst_n = 1'b1; chk_on = 1;
    rd(AM, v); chk("R7 por clears flag", v, 0);
    idle(2);
    finish_run();
  end
endmodule